// File: doc/BRIEF.md
# Configurable Logic Cell with Five-Input Expansion

This block is one logic cell of a programmable fabric. It holds two four-input lookup tables, called F and G. Each table stores a 16-bit truth table and produces one bit for its own four select inputs. The cell has two outputs. Output X always comes from table F. Output Y comes either from table G alone or from a 2-to-1 selection between the two tables, steered by a fifth input. In that combined mode, table G holds the half of a five-variable function where the fifth variable is 0, and table F holds the half where it is 1. The cell therefore realises any five-input function as `sel'·G + sel·F`.

Each output can be taken straight from its logic or from a flip-flop that captured that logic. Both flip-flops share a clock enable. A synchronous reset clears both flip-flops together with all configuration.

Configuration is written one word per clock through a small address/data port. Changes take effect on the clock edge that accepts the write.

Top module: `logic_cell`

## Requirements
- R1: While `rst` is high at a clock edge, both truth tables, the mode word and both flip-flops become zero. Right after reset, `x_out` and `y_out` read 0 for every input value.
- R2: `x_out` in direct mode equals bit `f_in` of table F. The table index is `{i3,i2,i1,i0}`, with `f_in[0]` as the least significant bit.
- R3: With the combine bit clear, `y_out` in direct mode equals bit `g_in` of table G, and `sel_in` has no effect on it.
- R4: With the combine bit set, `y_out` in direct mode equals bit `f_in` of table F when `sel_in` is 1, and bit `g_in` of table G when `sel_in` is 0.
- R5: `x_out` never depends on `sel_in` or on the combine bit.
- R6: With an output's register bit set, at each edge where `ce` is high that output takes the value its logic had just before the edge.
- R7: With an output's register bit set and `ce` low, that output holds its value across the edge.
- R8: The reset clears the flip-flops even when `ce` is low. After reset, selecting registered mode shows 0 until the first enabled edge.
- R9: A write with `cfg_we` high stores `cfg_wdata` into the word chosen by `cfg_addr`. Address 0 is table F, address 1 is table G, and address 2 is the mode word. In the mode word, bit 0 is combine, bit 1 selects registered X, and bit 2 selects registered Y. A write to address 3 changes nothing.
- R10: With `cfg_we` low, the values on `cfg_addr` and `cfg_wdata` change no configuration. A write becomes visible in the cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of configuration and flip-flops |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration word select |
| cfg_wdata | input | 16 | Configuration data (truth table or mode bits) |
| ce | input | 1 | Clock enable of both output flip-flops |
| f_in | input | 4 | Select inputs of table F |
| g_in | input | 4 | Select inputs of table G |
| sel_in | input | 1 | Fifth variable that chooses between the tables in combined mode |
| x_out | output | 1 | Output X (table F, direct or registered) |
| y_out | output | 1 | Output Y (table G or combined result, direct or registered) |

## Verification
In split mode, a fixed pair of sparse tables is swept with vectors. These vectors separate a wrong index order from a swapped table, and show that `sel_in` is ignored on Y.

A four-variable sum-of-products function is expanded about one variable into two halves. The combined output is then compared against the original expression for all 32 input values. This separates a mux with inverted polarity and a half loaded into the wrong table.

Random 32-bit truth tables, split across the two tables, test that every five-input function comes out intact. Directed sequences with the registered modes separate capture, hold and reset of the flip-flops from the direct path.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

  // Configuration word addresses.
  typedef enum logic [1:0] {
    CA_TAB_F = 2'd0,
    CA_TAB_G = 2'd1,
    CA_MODE  = 2'd2,
    CA_NONE  = 2'd3
  } cfg_addr_e;

  // Mode word: bit 0 combine, bit 1 registered X, bit 2 registered Y.
  typedef struct packed {
    logic reg_y;
    logic reg_x;
    logic combine;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

endpackage

// File: rtl/lcell_cfg.sv
module lcell_cfg
  import lcell_pkg::*;
#(
  parameter int K = 4,
  localparam int TW = 1 << K
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [1:0]    addr,
  input  logic [TW-1:0] wdata,
  output logic [TW-1:0] tab_f,
  output logic [TW-1:0] tab_g,
  output mode_t         mode
);

  always_ff @(posedge clk) begin
    if (rst) begin
      tab_f <= '0;
      tab_g <= '0;
      mode  <= '0;
    end else if (we) begin
      unique case (cfg_addr_e'(addr))
        CA_TAB_F: tab_f <= wdata;
        CA_TAB_G: tab_g <= wdata;
        CA_MODE:  mode  <= mode_t'(wdata[MODE_W-1:0]);
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/lcell_lut.sv
module lcell_lut #(
  parameter int K = 4,
  localparam int TW = 1 << K
) (
  input  logic [TW-1:0] tab,
  input  logic [K-1:0]  idx,
  output logic          o
);

  // Binary mux tree: level l halves the candidates using idx[l].
  logic [TW-1:0] lvl [K+1];

  assign lvl[0] = tab;

  for (genvar l = 0; l < K; l++) begin : g_lvl
    localparam int N = TW >> (l + 1);
    for (genvar n = 0; n < N; n++) begin : g_node
      assign lvl[l+1][n] = idx[l] ? lvl[l][2*n+1] : lvl[l][2*n];
    end
    if (N < TW) begin : g_pad
      assign lvl[l+1][TW-1:N] = '0;
    end
  end

  assign o = lvl[K][0];

endmodule

// File: rtl/lcell_outsel.sv
module lcell_outsel (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  input  logic d,
  input  logic use_reg,
  output logic q_ff,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst)     q_ff <= 1'b0;
    else if (ce) q_ff <= d;
  end

  assign q = use_reg ? q_ff : d;

endmodule

// File: rtl/logic_cell.sv
module logic_cell
  import lcell_pkg::*;
#(
  parameter int K = 4,
  localparam int TW = 1 << K,
  localparam int NLUT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [TW-1:0] cfg_wdata,
  input  logic          ce,
  input  logic [K-1:0]  f_in,
  input  logic [K-1:0]  g_in,
  input  logic          sel_in,
  output logic          x_out,
  output logic          y_out
);

  logic [TW-1:0] tab_f, tab_g;
  mode_t         mode_q;

  lcell_cfg #(.K(K)) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .tab_f (tab_f),
    .tab_g (tab_g),
    .mode  (mode_q)
  );

  // Index 0 is table F, index 1 is table G.
  logic [TW-1:0] tabs [NLUT];
  logic [K-1:0]  idxs [NLUT];
  logic          lut_o [NLUT];

  assign tabs[0] = tab_f;
  assign tabs[1] = tab_g;
  assign idxs[0] = f_in;
  assign idxs[1] = g_in;

  for (genvar i = 0; i < NLUT; i++) begin : g_lut
    lcell_lut #(.K(K)) u_lut (
      .tab (tabs[i]),
      .idx (idxs[i]),
      .o   (lut_o[i])
    );
  end

  // Expansion about the fifth variable: G holds sel=0 half, F holds sel=1 half.
  logic exp_o;
  assign exp_o = sel_in ? lut_o[0] : lut_o[1];

  logic comb_o  [NLUT];
  logic use_reg [NLUT];
  logic ff_o    [NLUT];
  logic out_o   [NLUT];

  assign comb_o[0]  = lut_o[0];
  assign comb_o[1]  = mode_q.combine ? exp_o : lut_o[1];
  assign use_reg[0] = mode_q.reg_x;
  assign use_reg[1] = mode_q.reg_y;

  for (genvar i = 0; i < NLUT; i++) begin : g_out
    lcell_outsel u_out (
      .clk     (clk),
      .rst     (rst),
      .ce      (ce),
      .d       (comb_o[i]),
      .use_reg (use_reg[i]),
      .q_ff    (ff_o[i]),
      .q       (out_o[i])
    );
  end

  assign x_out = out_o[0];
  assign y_out = out_o[1];

  // Flat views for the bound checker.
  logic chk_lut_f, chk_lut_g, chk_x_comb, chk_y_comb, chk_x_ff, chk_y_ff;
  logic chk_combine, chk_reg_x, chk_reg_y;
  assign chk_lut_f   = lut_o[0];
  assign chk_lut_g   = lut_o[1];
  assign chk_x_comb  = comb_o[0];
  assign chk_y_comb  = comb_o[1];
  assign chk_x_ff    = ff_o[0];
  assign chk_y_ff    = ff_o[1];
  assign chk_combine = mode_q.combine;
  assign chk_reg_x   = mode_q.reg_x;
  assign chk_reg_y   = mode_q.reg_y;

endmodule

// File: rtl/lcell_chk.sv
module lcell_chk (
  input logic clk,
  input logic rst,
  input logic ce,
  input logic cfg_we,
  input logic sel_in,
  input logic combine,
  input logic reg_x,
  input logic reg_y,
  input logic lut_f,
  input logic lut_g,
  input logic x_comb,
  input logic y_comb,
  input logic x_ff,
  input logic y_ff,
  input logic x_out,
  input logic y_out
);

  p_split_r3: assert property (@(posedge clk) disable iff (rst)
    (!combine && !reg_y) |-> (y_out == lut_g));

  p_join_r4: assert property (@(posedge clk) disable iff (rst)
    (combine && !reg_y) |-> (y_out == (sel_in ? lut_f : lut_g)));

  p_xfree_r5: assert property (@(posedge clk) disable iff (rst)
    !reg_x |-> (x_out == lut_f));

  p_capture_x_r6: assert property (@(posedge clk) disable iff (rst)
    (ce && reg_x && !cfg_we) |=> (x_out == $past(x_comb)));

  p_capture_y_r6: assert property (@(posedge clk) disable iff (rst)
    (ce && reg_y && !cfg_we) |=> (y_out == $past(y_comb)));

  p_hold_x_r7: assert property (@(posedge clk) disable iff (rst)
    (!ce && reg_x && !cfg_we) |=> $stable(x_out));

  p_hold_y_r7: assert property (@(posedge clk) disable iff (rst)
    (!ce && reg_y && !cfg_we) |=> $stable(y_out));

  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!x_ff && !y_ff));

endmodule

bind logic_cell lcell_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .ce      (ce),
  .cfg_we  (cfg_we),
  .sel_in  (sel_in),
  .combine (chk_combine),
  .reg_x   (chk_reg_x),
  .reg_y   (chk_reg_y),
  .lut_f   (chk_lut_f),
  .lut_g   (chk_lut_g),
  .x_comb  (chk_x_comb),
  .y_comb  (chk_y_comb),
  .x_ff    (chk_x_ff),
  .y_ff    (chk_y_ff),
  .x_out   (x_out),
  .y_out   (y_out)
);

// File: tb/tb_logic_cell.sv
`timescale 1ns/1ps
module tb_logic_cell;

  localparam int K  = 4;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = '0;
  logic [TW-1:0] cfg_wdata = '0;
  logic          ce = 1'b0;
  logic [K-1:0]  f_in = '0;
  logic [K-1:0]  g_in = '0;
  logic          sel_in = 1'b0;
  logic          x_out, y_out;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  logic_cell #(.K(K)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ce(ce), .f_in(f_in), .g_in(g_in),
    .sel_in(sel_in), .x_out(x_out), .y_out(y_out)
  );

  // Split-mode vectors with F=16'h8001, G=16'h0100: {f_in, g_in, sel, exp_x, exp_y}
  localparam logic [10:0] VEC [6] = '{
    {4'd0,  4'd8, 1'b0, 1'b1, 1'b1},
    {4'd15, 4'd0, 1'b0, 1'b1, 1'b0},
    {4'd1,  4'd8, 1'b0, 1'b0, 1'b1},
    {4'd7,  4'd9, 1'b0, 1'b0, 1'b0},
    {4'd15, 4'd8, 1'b1, 1'b1, 1'b1},
    {4'd0,  4'd7, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [TW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drive(input logic [3:0] fv, input logic [3:0] gv, input logic s);
    @(negedge clk);
    f_in = fv; g_in = gv; sel_in = s;
    #1;
  endtask

  function automatic logic f_orig(input logic a, b, c, d);
    return (!c && !d) || (!a && !b && c) || (b && c && d) || (a && !c);
  endfunction
  function automatic logic f_lo(input logic b, c, d);
    return (!c && !d) || (!b && c) || (c && d);
  endfunction
  function automatic logic f_hi(input logic b, c, d);
    return !c || (b && d);
  endfunction

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [TW-1:0] t_lo, t_hi;
    logic [31:0]   tt;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state, all tables zero.
    drive(4'd0, 4'd0, 1'b0);  chk("R1 x", x_out, 1'b0); chk("R1 y", y_out, 1'b0);
    drive(4'd15, 4'd9, 1'b1); chk("R1 x", x_out, 1'b0); chk("R1 y", y_out, 1'b0);

    // R9: load split-mode tables and mode word 0.
    cfg_write(2'd0, 16'h8001);
    cfg_write(2'd1, 16'h0100);
    cfg_write(2'd2, 16'h0000);
    for (int i = 0; i < 6; i++) begin
      drive(VEC[i][10:7], VEC[i][6:3], VEC[i][2]);
      chk("R2 x table F", x_out, VEC[i][1]);
      chk("R3 y table G", y_out, VEC[i][0]);
    end

    // R10: data on the port with the strobe low changes nothing.
    @(negedge clk);
    cfg_addr = 2'd0; cfg_wdata = 16'hFFFF;
    @(negedge clk);
    drive(4'd7, 4'd0, 1'b0);
    chk("R10 no strobe", x_out, 1'b0);

    // R9: address 3 is ignored (tables and mode unchanged).
    cfg_write(2'd3, 16'hFFFF);
    drive(4'd7, 4'd0, 1'b1);
    chk("R9 addr3 F", x_out, 1'b0);
    chk("R9 addr3 G/mode", y_out, 1'b0);

    // R4: Shannon pair; G holds a=0 half, F holds a=1 half; index {i3,b,c,d}.
    for (int j = 0; j < TW; j++) begin
      t_lo[j] = f_lo(j[2], j[1], j[0]);
      t_hi[j] = f_hi(j[2], j[1], j[0]);
    end
    cfg_write(2'd0, t_hi);
    cfg_write(2'd1, t_lo);
    cfg_write(2'd2, 16'h0001);
    for (int v = 0; v < 32; v++) begin
      drive(v[3:0], v[3:0], v[4]);
      chk("R4 combined", y_out, f_orig(v[4], v[2], v[1], v[0]));
      chk("R5 x ignores sel", x_out, f_hi(v[2], v[1], v[0]));
    end

    // R4: random five-input functions, table split at bit 16.
    for (int r = 0; r < 4; r++) begin
      tt = $urandom;
      cfg_write(2'd0, tt[31:16]);
      cfg_write(2'd1, tt[15:0]);
      for (int v = 0; v < 32; v++) begin
        drive(v[3:0], v[3:0], v[4]);
        chk("R4 random", y_out, tt[v]);
      end
    end

    // R6: registered outputs, combined mode.
    cfg_write(2'd0, 16'h8001);
    cfg_write(2'd1, 16'h0100);
    cfg_write(2'd2, 16'h0007);
    @(negedge clk);
    f_in = 4'd0; g_in = 4'd8; sel_in = 1'b0; ce = 1'b1;
    @(negedge clk);
    chk("R6 x capture", x_out, 1'b1);
    chk("R6 y capture", y_out, 1'b1);

    // R7: hold with enable low.
    ce = 1'b0; f_in = 4'd7; g_in = 4'd0;
    @(negedge clk);
    @(negedge clk);
    chk("R7 x hold", x_out, 1'b1);
    chk("R7 y hold", y_out, 1'b1);

    // R8: reset clears flip-flops with enable low.
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    drive(4'd0, 4'd8, 1'b0);
    chk("R1 x after reset", x_out, 1'b0);
    chk("R1 y after reset", y_out, 1'b0);
    cfg_write(2'd0, 16'hFFFF);
    cfg_write(2'd1, 16'hFFFF);
    cfg_write(2'd2, 16'h0006);
    #1;
    chk("R8 x ff cleared", x_out, 1'b0);
    chk("R8 y ff cleared", y_out, 1'b0);
    ce = 1'b1;
    @(negedge clk);
    ce = 1'b0;
    chk("R6 x after enable", x_out, 1'b1);
    chk("R6 y after enable", y_out, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule